// File: doc/BRIEF.md
# Sync pulse output controller

This block turns trigger events from an external clock-compare engine into sync pulses on two independent channels. A trigger on a channel asserts that channel's sync signal for a programmed number of clock ticks. The tick count comes from a 16-bit length register. When the length is zero, the channel enters acknowledged mode: the sync signal then stays asserted until software strobes that channel's acknowledge.

Each channel's sync signal is always available internally as an event strobe, for example for digital I/O update and latch logic, whatever the pin mapping. A sync event can also set a per-channel interrupt-request bit, if that channel's interrupt enable is set. The OR of these bits drives a single interrupt line.

Each channel owns one shared pin, and a configuration register maps it either as a sync output or as a latch input. The same register selects a push-pull or an open-drain driver for the pin. All shared pins stay released (high-impedance) until the configuration-loaded input is high. Software reaches the two registers through a simple write port that returns a one-cycle acknowledge.

Top module: `sync_pulse_ctrl`

## Requirements
- R1: While rst_n is low, sync_evt, irq_req, irq_o, pin_oe, pin_out, latch_o and reg_wr_ack are all zero. After reset the pulse length is 0 and every channel is in sync-output, push-pull mode with its interrupt disabled.
- R2: A cycle with reg_wr_en high writes reg_wr_data into a register on the next edge. Address 0 is the configuration register; for channel c, bit 4c+0 selects latch mode, bit 4c+1 selects open drain, bit 4c+2 enables the interrupt, and bit 4c+3 is ignored. Address 1 is the 16-bit pulse length. reg_wr_ack is high in the cycle after each write cycle and low otherwise.
- R3: A trigger sampled at an edge while the length register holds L > 0 makes that channel's sync_evt high for exactly L cycles, starting right after that edge. The length is taken at trigger time. sync_evt never rises without a trigger.
- R4: A trigger that arrives while a timed pulse is active restarts the count, so the output stays high for L cycles after the latest trigger.
- R5: A trigger sampled while the length is 0 holds sync_evt high until an acknowledge on that channel is sampled without a trigger; it then drops after that edge. When the acknowledge and a trigger arrive in the same cycle, the trigger wins. An acknowledge has no effect on a timed pulse.
- R6: A trigger on a channel whose interrupt enable is set raises irq_req for that channel after the edge. An acknowledge without a trigger clears it, and a trigger with the enable set wins over a simultaneous acknowledge. With the enable clear, a trigger does not set the bit. irq_o is the OR of the irq_req bits.
- R7: A loaded pin in sync-output mode with push-pull drive has pin_oe=1 and pin_out equal to sync_evt. With open drain it has pin_out=0 and pin_oe equal to the inverse of sync_evt. Both are registered and change at the same edge as sync_evt.
- R8: A pin in latch mode has pin_oe=0 and pin_out=0, and latch_o follows pin_in combinationally. In sync mode, latch_o is 0.
- R9: While cfg_loaded is low, every pin is released (pin_oe=0, pin_out=0) and latch_o is 0, from the next edge on. sync_evt and irq_req keep working unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_loaded | input | 1 | Configuration loaded; releases pins while low |
| trig | input | 2 | Per-channel trigger strobes from the compare engine |
| sync_ack | input | 2 | Per-channel software acknowledge strobes |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 1 | 0 = configuration, 1 = pulse length |
| reg_wr_data | input | 16 | Write data |
| reg_wr_ack | output | 1 | Write acknowledge, one cycle after the write |
| sync_evt | output | 2 | Internal sync signals, independent of pin mapping |
| irq_req | output | 2 | Per-channel interrupt-request bits |
| irq_o | output | 1 | Combined interrupt line |
| pin_in | input | 2 | Value seen on each shared pin |
| pin_oe | output | 2 | Output enable for each shared pin |
| pin_out | output | 2 | Output value for each shared pin |
| latch_o | output | 2 | Latch input forwarded from pins in latch mode |

## Verification
The bench goes after the edges of the pulse counter: a length of 1, and a retrigger in the middle of a pulse. A design that got the count wrong would give a pulse one cycle too long or too short, or would end the pulse early after a retrigger. It also hits acknowledged mode with an acknowledge and a trigger in the same cycle, and a stray acknowledge during a timed pulse. A wrong priority would drop a held output or clear an interrupt that should survive. The open-drain inversion, latch mapping and unloaded pins are checked too: the wrong polarity or a pin driven before loading shows up on pin_oe and pin_out, while sync_evt must keep toggling.

// File: rtl/sync_pkg.sv
package sync_pkg;
  localparam int CFG_STRIDE = 4;

  typedef struct packed {
    logic irq_en;
    logic open_drain;
    logic latch_mode;
  } ch_cfg_t;

  localparam int CH_CFG_W = $bits(ch_cfg_t);

  // Returns {oe, out} for a shared pin given its level and mapping.
  function automatic logic [1:0] pin_drive(ch_cfg_t cfg, logic loaded, logic level);
    if (!loaded || cfg.latch_mode) return 2'b00;
    if (cfg.open_drain)            return {~level, 1'b0};
    return {1'b1, level};
  endfunction
endpackage

// File: rtl/sync_cfg_regs.sv
module sync_cfg_regs
  import sync_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic                         wr_ack,
  output logic [NUM_CH*CH_CFG_W-1:0]   cfg_o,
  output logic [LEN_W-1:0]             len_o
);
  localparam int CFG_W = NUM_CH * CH_CFG_W;

  logic [CFG_W-1:0] cfg_wr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pack
    assign cfg_wr[c*CH_CFG_W +: CH_CFG_W] = wr_data[c*CFG_STRIDE +: CH_CFG_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_o  <= '0;
      len_o  <= '0;
      wr_ack <= 1'b0;
    end else begin
      wr_ack <= wr_en;
      if (wr_en && !wr_addr) cfg_o <= cfg_wr;
      if (wr_en &&  wr_addr) len_o <= wr_data[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/sync_channel.sv
module sync_channel #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             ack,
  input  logic [LEN_W-1:0] len,
  input  logic             irq_en,
  output logic             sync_next,
  output logic             sync_o,
  output logic             irq_o
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             hold_q, hold_d;
  logic             irq_d;

  function automatic logic [LEN_W-1:0] count_step(logic [LEN_W-1:0] cnt);
    return (cnt != '0) ? cnt - 1'b1 : '0;
  endfunction

  always_comb begin
    if (trig) begin
      sync_next = 1'b1;
      cnt_d     = len;
      hold_d    = (len == '0);
    end else if (hold_q) begin
      sync_next = ~ack;
      cnt_d     = '0;
      hold_d    = ~ack;
    end else begin
      sync_next = (cnt_q > 1);
      cnt_d     = count_step(cnt_q);
      hold_d    = 1'b0;
    end
    irq_d = (trig & irq_en) | (irq_o & ~ack);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
      sync_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      sync_o <= sync_next;
      irq_o  <= irq_d;
    end
  end
endmodule

// File: rtl/sync_pin_stage.sv
module sync_pin_stage
  import sync_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ch_cfg_t cfg,
  input  logic    loaded,
  input  logic    level_next,
  input  logic    pin_in,
  output logic    oe,
  output logic    out,
  output logic    latch
);
  logic [1:0] drive_d;

  assign drive_d = pin_drive(cfg, loaded, level_next);
  assign latch   = loaded & cfg.latch_mode & pin_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe  <= 1'b0;
      out <= 1'b0;
    end else begin
      oe  <= drive_d[1];
      out <= drive_d[0];
    end
  end
endmodule

// File: rtl/sync_pulse_ctrl.sv
module sync_pulse_ctrl
  import sync_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_loaded,
  input  logic [NUM_CH-1:0] trig,
  input  logic [NUM_CH-1:0] sync_ack,
  input  logic              reg_wr_en,
  input  logic              reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic              reg_wr_ack,
  output logic [NUM_CH-1:0] sync_evt,
  output logic [NUM_CH-1:0] irq_req,
  output logic              irq_o,
  input  logic [NUM_CH-1:0] pin_in,
  output logic [NUM_CH-1:0] pin_oe,
  output logic [NUM_CH-1:0] pin_out,
  output logic [NUM_CH-1:0] latch_o
);
  localparam int CFG_W = NUM_CH * CH_CFG_W;

  logic [CFG_W-1:0]  cfg_q;
  logic [LEN_W-1:0]  len_q;
  logic [NUM_CH-1:0] sync_next;

  sync_cfg_regs #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .DATA_W(DATA_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .wr_ack  (reg_wr_ack),
    .cfg_o   (cfg_q),
    .len_o   (len_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ch_cfg_t ch_cfg;
    assign ch_cfg = ch_cfg_t'(cfg_q[c*CH_CFG_W +: CH_CFG_W]);

    sync_channel #(.LEN_W(LEN_W)) chan_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig[c]),
      .ack       (sync_ack[c]),
      .len       (len_q),
      .irq_en    (ch_cfg.irq_en),
      .sync_next (sync_next[c]),
      .sync_o    (sync_evt[c]),
      .irq_o     (irq_req[c])
    );

    sync_pin_stage pin_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (ch_cfg),
      .loaded     (cfg_loaded),
      .level_next (sync_next[c]),
      .pin_in     (pin_in[c]),
      .oe         (pin_oe[c]),
      .out        (pin_out[c]),
      .latch      (latch_o[c])
    );
  end

  assign irq_o = |irq_req;
endmodule

// File: rtl/sync_pulse_ctrl_chk.sv
module sync_pulse_ctrl_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_loaded,
  input logic [NUM_CH-1:0] trig,
  input logic [NUM_CH-1:0] sync_ack,
  input logic [NUM_CH*3-1:0] cfg,
  input logic              reg_wr_en,
  input logic              reg_wr_ack,
  input logic [NUM_CH-1:0] sync_evt,
  input logic [NUM_CH-1:0] irq_req,
  input logic [NUM_CH-1:0] pin_oe,
  input logic [NUM_CH-1:0] pin_out
);
  assert_wr_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_wr_ack);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_trig_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      trig[c] |=> sync_evt[c]);
    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig[c] && !sync_evt[c]) |=> !sync_evt[c]);
    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_ack[c] && !trig[c]) |=> !irq_req[c]);
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg[c*3+2] && !irq_req[c]) |=> !irq_req[c]);
    assert_pushpull_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_loaded && !cfg[c*3] && !cfg[c*3+1]) |=> (pin_oe[c] && (pin_out[c] == sync_evt[c])));
    assert_latch_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[c*3] |=> (!pin_oe[c] && !pin_out[c]));
    assert_unloaded_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_loaded |=> (!pin_oe[c] && !pin_out[c]));
  end
endmodule

bind sync_pulse_ctrl sync_pulse_ctrl_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_loaded (cfg_loaded),
  .trig       (trig),
  .sync_ack   (sync_ack),
  .cfg        (cfg_q),
  .reg_wr_en  (reg_wr_en),
  .reg_wr_ack (reg_wr_ack),
  .sync_evt   (sync_evt),
  .irq_req    (irq_req),
  .pin_oe     (pin_oe),
  .pin_out    (pin_out)
);

// File: tb/sync_pulse_ctrl_tb_top.sv
module sync_pulse_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_loaded = 1'b0;
  logic [NCH-1:0] trig = '0, sync_ack = '0, pin_in = '0;
  logic reg_wr_en = 1'b0, reg_wr_addr = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic reg_wr_ack, irq_o;
  logic [NCH-1:0] sync_evt, irq_req, pin_oe, pin_out, latch_o;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_pulse_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_loaded(cfg_loaded), .trig(trig),
    .sync_ack(sync_ack), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_wr_ack(reg_wr_ack), .sync_evt(sync_evt),
    .irq_req(irq_req), .irq_o(irq_o), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .latch_o(latch_o)
  );

  // Behavioural reference model
  int  rem_m [NCH];
  bit  hold_m[NCH], act_m[NCH], irq_m[NCH], oe_m[NCH], out_m[NCH];
  bit [7:0] cfg_m;
  int  len_m;
  bit  ack_m;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        rem_m[c] = 0; hold_m[c] = 0; act_m[c] = 0; irq_m[c] = 0; oe_m[c] = 0; out_m[c] = 0;
      end
      cfg_m = 0; len_m = 0; ack_m = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (trig[c]) begin
          act_m[c] = 1;
          if (len_m == 0) begin hold_m[c] = 1; rem_m[c] = 0; end
          else begin hold_m[c] = 0; rem_m[c] = len_m; end
        end else if (hold_m[c]) begin
          if (sync_ack[c]) begin hold_m[c] = 0; act_m[c] = 0; end
        end else begin
          if (rem_m[c] > 0) rem_m[c]--;
          act_m[c] = (rem_m[c] > 0);
        end
        if (trig[c] && cfg_m[4*c+2]) irq_m[c] = 1;
        else if (sync_ack[c]) irq_m[c] = 0;
        if (!cfg_loaded || cfg_m[4*c]) begin oe_m[c] = 0; out_m[c] = 0; end
        else if (cfg_m[4*c+1]) begin oe_m[c] = !act_m[c]; out_m[c] = 0; end
        else begin oe_m[c] = 1; out_m[c] = act_m[c]; end
      end
      ack_m = reg_wr_en;
      if (reg_wr_en && !reg_wr_addr) cfg_m = reg_wr_data[7:0];
      if (reg_wr_en && reg_wr_addr)  len_m = int'(reg_wr_data);
    end
  end

  task automatic chk(string req, string name, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d at %0t", req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "reg_wr_ack", int'(reg_wr_ack), int'(ack_m));
      for (int c = 0; c < NCH; c++) begin
        bit lat;
        lat = cfg_loaded && cfg_m[4*c] && pin_in[c];
        chk(cur_req, $sformatf("sync_evt[%0d]", c), int'(sync_evt[c]), int'(act_m[c]));
        chk(cur_req, $sformatf("irq_req[%0d]", c),  int'(irq_req[c]),  int'(irq_m[c]));
        chk(cur_req, $sformatf("pin_oe[%0d]", c),   int'(pin_oe[c]),   int'(oe_m[c]));
        chk(cur_req, $sformatf("pin_out[%0d]", c),  int'(pin_out[c]),  int'(out_m[c]));
        chk(cur_req, $sformatf("latch_o[%0d]", c),  int'(latch_o[c]),  int'(lat));
      end
      chk(cur_req, "irq_o", int'(irq_o), int'(irq_m[0] | irq_m[1]));
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(bit a, logic [15:0] d);
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    cyc();
    reg_wr_en = 0;
  endtask

  task automatic fire(logic [NCH-1:0] t, logic [NCH-1:0] k);
    trig = t; sync_ack = k;
    cyc();
    trig = 0; sync_ack = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cur_req = "R1";
    cyc(3);
    chk("R1", "sync_evt in reset", int'(sync_evt), 0);
    chk("R1", "pin_oe in reset", int'(pin_oe), 0);
    chk("R1", "irq_o in reset", int'(irq_o), 0);
    chk("R1", "reg_wr_ack in reset", int'(reg_wr_ack), 0);
    cfg_loaded = 1;
    rst_n = 1;
    cyc(2);

    cur_req = "R2";
    wr(0, 16'h0444);
    wr(1, 16'd3);
    cyc(2);

    cur_req = "R3";
    fire(2'b01, 0); cyc(5);
    fire(2'b10, 0); cyc(5);
    wr(1, 16'd1);
    fire(2'b11, 0); cyc(3);

    cur_req = "R4";
    wr(1, 16'd4);
    fire(2'b01, 0); cyc(2);
    fire(2'b01, 0); cyc(6);

    cur_req = "R5";
    fire(2'b01, 2'b01);  // ack on timed pulse, no effect on output
    cyc(1); fire(0, 2'b01); cyc(4);
    wr(1, 16'd0);
    fire(2'b11, 0); cyc(4);
    fire(0, 2'b01); cyc(2);
    fire(2'b10, 2'b10); cyc(2);
    fire(0, 2'b10); cyc(2);

    cur_req = "R6";
    wr(0, 16'h0400);
    wr(1, 16'd2);
    fire(2'b11, 0); cyc(3);
    fire(2'b10, 2'b10); cyc(2);
    fire(0, 2'b11); cyc(2);

    cur_req = "R7";
    wr(0, 16'h0002);
    fire(2'b11, 0); cyc(4);

    cur_req = "R8";
    wr(0, 16'h0010);
    for (int i = 0; i < 6; i++) begin
      pin_in = NCH'(i);
      if (i == 2) fire(2'b11, 0); else cyc();
    end
    cyc(3);

    cur_req = "R9";
    wr(0, 16'h0414);
    cfg_loaded = 0;
    pin_in = 2'b11;
    fire(2'b11, 0); cyc(3);
    cfg_loaded = 1;
    cyc(2);

    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      trig        = NCH'($urandom_range(0, 3) & ($urandom_range(0, 3) == 0 ? 3 : 0));
      sync_ack    = NCH'($urandom_range(0, 3) & ($urandom_range(0, 2) == 0 ? 3 : 0));
      pin_in      = NCH'($urandom_range(0, 3));
      cfg_loaded  = ($urandom_range(0, 15) != 0);
      reg_wr_en   = ($urandom_range(0, 19) == 0);
      reg_wr_addr = $urandom_range(0, 1) == 1;
      reg_wr_data = reg_wr_addr ? 16'($urandom_range(0, 5)) : 16'($urandom_range(0, 255) & 16'h0077);
      cyc();
    end
    trig = 0; sync_ack = 0; reg_wr_en = 0;
    cyc(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule